// File: doc/BRIEF.md
# Invalidation Ack Count Tracker

This block supplies the acknowledgement bookkeeping for a shared cache level that keeps a sharer bit-vector per line. It has two parts. The first is a combinational path that turns the current sharer vector, the identity of the requesting client and the kind of response being built into a signed ack-count field. The requester adds that number to the invalidation acks it receives, and the write may complete when the total reaches zero. Counts are negative: minus the number of clients that must still answer. The requester is left out of that number when it is already a sharer.

The second part is a pending-ack register used while a line is being evicted. A replacement loads it with the number of sharers. Each arriving ack message subtracts the count it carries. The register raises a one-cycle "all acks in" pulse when the difference reaches exactly zero, and a separate one-cycle "more pending" pulse for any other accepted ack. If the remaining count would drop below zero, a sticky error flag is set. Message routing and the data payload are handled elsewhere.

Top module: `ack_count_tracker`

## Requirements
- R1: For response kind 0 (write data) and kind 1 (exclusive data), `rsp_ack_count` equals minus the population count of `sharers`, plus one when `sharers[req_id]` is set. It is valid in the same cycle as its inputs.
- R2: For response kind 2 (shared read data), `rsp_ack_count` is zero whatever the sharer vector and requester are.
- R3: For response kind 3 (upgrade ack), `rsp_ack_count` equals one minus the population count of `sharers`, whether or not the requester is a sharer.
- R4: While `rst` is high and after it falls, `pending` is zero and `ack_all`, `ack_more` and `underflow` are low until a load or an ack is accepted.
- R5: A cycle with `repl_load` high sets `pending` after that clock edge to the population count of `sharers`, clears `underflow`, and raises neither pulse.
- R6: A cycle with `ack_valid` high and `repl_load` low sets `pending` after the edge to the old `pending` minus `ack_count`, taken modulo the counter width.
- R7: After such an accepted ack, `ack_all` is high for exactly the next cycle if old `pending` minus `ack_count` is zero. Otherwise `ack_more` is high for that cycle. The two are never high together.
- R8: If an accepted ack makes old `pending` minus `ack_count` negative, `underflow` goes high after that edge. It stays high until the next load or reset.
- R9: When `repl_load` and `ack_valid` are high in the same cycle, the load takes effect and the ack is ignored: no pulse, and `pending` takes the population count.
- R10: In a cycle with neither `repl_load` nor `ack_valid`, `pending` and `underflow` hold their values and both pulses are low after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sharers | input | NUM_CLIENTS (16) | Sharer bit-vector, one bit per client |
| req_id | input | ID_W (4) | Requesting client index |
| rsp_kind | input | 2 | 0 write data, 1 exclusive data, 2 shared data, 3 upgrade ack |
| rsp_ack_count | output | CNT_W (6) | Signed ack-count field for the response being built |
| repl_load | input | 1 | Start of replacement: load pending with sharer count |
| ack_valid | input | 1 | An ack message is accepted this cycle |
| ack_count | input | CNT_W (6) | Signed count carried by the ack message |
| pending | output | CNT_W (6) | Signed remaining ack count |
| ack_all | output | 1 | One-cycle pulse: the accepted ack brought the count to zero |
| ack_more | output | 1 | One-cycle pulse: the accepted ack left a nonzero count |
| underflow | output | 1 | Sticky flag: the remaining count went below zero |

## Verification
`rsp_ack_count` has no register on its path, so it is due in the cycle the inputs change. The bench drives inputs just after a falling edge and samples the field 1 ns later, well before the next rising edge. `pending`, `ack_all`, `ack_more` and `underflow` pass through one register each. They are due one rising edge after the stimulus cycle and are sampled 2 ns after that edge, compared with a behavioural model that is advanced once per stimulus cycle. Directed sequences cover exact completion, underflow and a load that collides with an ack. A long random run then mixes sharer vectors, requesters, kinds and ack counts.

// File: rtl/ack_pkg.sv
`timescale 1ns/1ps
package ack_pkg;

    typedef enum logic [1:0] {
        RSP_DATA    = 2'd0,
        RSP_EXCL    = 2'd1,
        RSP_SHARED  = 2'd2,
        RSP_UPGRADE = 2'd3
    } rsp_kind_e;

    typedef struct packed {
        logic all_done;
        logic more_pending;
    } ack_evt_t;

    // signed width able to hold +clients and -clients
    function automatic int cnt_width(input int clients);
        return $clog2(clients + 1) + 1;
    endfunction

    function automatic int id_width(input int clients);
        return (clients > 1) ? $clog2(clients) : 1;
    endfunction

endpackage

// File: rtl/ack_popcount.sv
`timescale 1ns/1ps
module ack_popcount #(
    parameter int VEC_W = 16,
    parameter int OUT_W = 6
) (
    input  logic [VEC_W-1:0] vec,
    output logic [OUT_W-1:0] count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < VEC_W; i++) begin
            count = count + OUT_W'(vec[i]);
        end
    end
endmodule

// File: rtl/ack_resp_count.sv
`timescale 1ns/1ps
module ack_resp_count
    import ack_pkg::*;
#(
    parameter int NUM_CLIENTS = 16,
    parameter int ID_W        = 4,
    parameter int CNT_W       = 6
) (
    input  logic [NUM_CLIENTS-1:0] sharers,
    input  logic [ID_W-1:0]        req_id,
    input  logic [CNT_W-1:0]       pop,
    input  rsp_kind_e              kind,
    output logic [CNT_W-1:0]       count
);
    logic             is_member;
    logic [CNT_W-1:0] neg_pop;

    always_comb begin
        is_member = 1'b0;
        for (int i = 0; i < NUM_CLIENTS; i++) begin
            if (ID_W'(i) == req_id) is_member = sharers[i];
        end
    end

    assign neg_pop = CNT_W'(0) - pop;

    always_comb begin
        unique case (kind)
            RSP_DATA, RSP_EXCL: count = neg_pop + CNT_W'(is_member);
            RSP_SHARED:         count = '0;
            RSP_UPGRADE:        count = neg_pop + CNT_W'(1);
            default:            count = '0;
        endcase
    end

    // a shared response never asks for acks; upgrade never exceeds +1
    always_comb begin
        if (kind == RSP_SHARED) begin
            AST_SHARED_ZERO: assert (count == '0); // R2
        end
    end
endmodule

// File: rtl/ack_pending_tracker.sv
`timescale 1ns/1ps
module ack_pending_tracker
    import ack_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_value,
    input  logic             ack_valid,
    input  logic [CNT_W-1:0] ack_cnt,
    output logic [CNT_W-1:0] pending,
    output ack_evt_t         evt,
    output logic             underflow
);
    logic [CNT_W:0] diff;
    logic           diff_zero;
    logic           diff_neg;

    // one extra bit so the sign of the difference is exact
    assign diff      = {pending[CNT_W-1], pending} - {ack_cnt[CNT_W-1], ack_cnt};
    assign diff_zero = (diff == '0);
    assign diff_neg  = diff[CNT_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            pending   <= '0;
            evt       <= '0;
            underflow <= 1'b0;
        end else begin
            evt <= '0;
            if (load) begin
                pending   <= load_value;
                underflow <= 1'b0;
            end else if (ack_valid) begin
                pending          <= diff[CNT_W-1:0];
                evt.all_done     <= diff_zero;
                evt.more_pending <= !diff_zero;
                if (diff_neg) underflow <= 1'b1;
            end
        end
    end

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(evt.all_done && evt.more_pending)); // R7
    AST_ACK_PULSES: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && !load) |=> (evt.all_done || evt.more_pending)); // R7
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        load |=> (!evt.all_done && !evt.more_pending && !underflow)); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!load && !ack_valid) |=> ($stable(pending) && !evt.all_done && !evt.more_pending)); // R10
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (underflow && !load) |=> underflow); // R8
endmodule

// File: rtl/ack_count_tracker.sv
`timescale 1ns/1ps
module ack_count_tracker
    import ack_pkg::*;
#(
    parameter  int NUM_CLIENTS = 16,
    localparam int ID_W        = id_width(NUM_CLIENTS),
    localparam int CNT_W       = cnt_width(NUM_CLIENTS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_CLIENTS-1:0] sharers,
    input  logic [ID_W-1:0]        req_id,
    input  logic [1:0]             rsp_kind,
    output logic [CNT_W-1:0]       rsp_ack_count,
    input  logic                   repl_load,
    input  logic                   ack_valid,
    input  logic [CNT_W-1:0]       ack_count,
    output logic [CNT_W-1:0]       pending,
    output logic                   ack_all,
    output logic                   ack_more,
    output logic                   underflow
);
    logic [CNT_W-1:0] pop;
    ack_evt_t         evt;
    rsp_kind_e        kind;

    assign kind = rsp_kind_e'(rsp_kind);

    ack_popcount #(.VEC_W(NUM_CLIENTS), .OUT_W(CNT_W)) u_pop (
        .vec   (sharers),
        .count (pop)
    );

    ack_resp_count #(.NUM_CLIENTS(NUM_CLIENTS), .ID_W(ID_W), .CNT_W(CNT_W)) u_resp (
        .sharers (sharers),
        .req_id  (req_id),
        .pop     (pop),
        .kind    (kind),
        .count   (rsp_ack_count)
    );

    ack_pending_tracker #(.CNT_W(CNT_W)) u_track (
        .clk        (clk),
        .rst        (rst),
        .load       (repl_load),
        .load_value (pop),
        .ack_valid  (ack_valid),
        .ack_cnt    (ack_count),
        .pending    (pending),
        .evt        (evt),
        .underflow  (underflow)
    );

    assign ack_all  = evt.all_done;
    assign ack_more = evt.more_pending;

    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
        repl_load |=> (pending == $past(pop))); // R5
endmodule

// File: tb/tb_ack_count_tracker.sv
`timescale 1ns/1ps
module tb_ack_count_tracker;
    localparam int N = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N-1:0]      sharers = '0;
    logic [3:0]        req_id = '0;
    logic [1:0]        rsp_kind = '0;
    logic signed [5:0] rsp_ack_count;
    logic              repl_load = 1'b0;
    logic              ack_valid = 1'b0;
    logic signed [5:0] ack_count = '0;
    logic signed [5:0] pending;
    logic              ack_all, ack_more, underflow;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // behavioural model state
    int  m_pend = 0;
    bit  m_err = 0, m_all = 0, m_more = 0;

    always #4 clk = ~clk;

    ack_count_tracker #(.NUM_CLIENTS(N)) dut (
        .clk(clk), .rst(rst), .sharers(sharers), .req_id(req_id),
        .rsp_kind(rsp_kind), .rsp_ack_count(rsp_ack_count),
        .repl_load(repl_load), .ack_valid(ack_valid), .ack_count(ack_count),
        .pending(pending), .ack_all(ack_all), .ack_more(ack_more),
        .underflow(underflow)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int wrap6(input int v);
        int w;
        w = ((v % 64) + 64) % 64;
        return (w >= 32) ? w - 64 : w;
    endfunction

    task automatic step(input logic [N-1:0] sh, input int id, input int kind,
                        input bit ld, input bit av, input int ac);
        int pop, exp_rsp, d;
        string preq, ereq;
        @(negedge clk);
        sharers = sh; req_id = 4'(id); rsp_kind = 2'(kind);
        repl_load = ld; ack_valid = av; ack_count = 6'(ac);
        #1;
        pop = $countones(sh);
        case (kind)
            0, 1: begin exp_rsp = -pop + int'(sh[id]); chk("R1", int'(rsp_ack_count), exp_rsp); end
            2:    chk("R2", int'(rsp_ack_count), 0);
            default: begin exp_rsp = 1 - pop; chk("R3", int'(rsp_ack_count), exp_rsp); end
        endcase
        m_all = 0; m_more = 0;
        if (ld) begin
            m_pend = pop; m_err = 0;
            preq = av ? "R9" : "R5"; ereq = preq;
        end else if (av) begin
            d = m_pend - ac;
            m_all = (d == 0); m_more = (d != 0);
            if (d < 0) m_err = 1;
            m_pend = wrap6(d);
            preq = "R6"; ereq = "R8";
        end else begin
            preq = "R10"; ereq = "R10";
        end
        @(posedge clk);
        #2;
        chk(preq, int'(pending), m_pend);
        chk(av && !ld ? "R7" : preq, int'(ack_all), int'(m_all));
        chk(av && !ld ? "R7" : preq, int'(ack_more), int'(m_more));
        chk(ereq, int'(underflow), int'(m_err));
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk("R4", int'(pending), 0);
        chk("R4", int'(ack_all), 0);
        chk("R4", int'(ack_more), 0);
        chk("R4", int'(underflow), 0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #2;
        chk("R4", int'(pending), 0);
        chk("R4", int'(underflow), 0);

        // R1/R3 directed: requester sharer vs not
        step(16'h000B, 1, 0, 0, 0, 0);   // R1 member: -3+1
        step(16'h000B, 2, 1, 0, 0, 0);   // R1 non-member: -3
        step(16'hFFFF, 5, 3, 0, 0, 0);   // R3 all sharers: -15
        step(16'h0000, 0, 3, 0, 0, 0);   // R3 no sharers: +1
        step(16'hFFFF, 0, 2, 0, 0, 0);   // R2 zero
        step(16'hFFFF, 15, 0, 0, 0, 0);  // R1 -16+1

        // R5 then R6/R7 exact completion
        step(16'h000B, 0, 2, 1, 0, 0);   // load 3
        step(16'h0000, 0, 2, 0, 1, 1);   // more
        step(16'h0000, 0, 2, 0, 0, 0);   // R10 idle
        step(16'h0000, 0, 2, 0, 1, 1);   // more
        step(16'h0000, 0, 2, 0, 1, 1);   // all
        // R8 underflow, sticky, cleared by load
        step(16'h0000, 0, 2, 0, 1, 2);
        step(16'h0000, 0, 2, 0, 0, 0);
        step(16'h00F0, 0, 2, 1, 0, 0);   // load 4 clears
        step(16'h0000, 0, 2, 0, 1, 4);   // all in one message
        // R9 collision
        step(16'h0303, 0, 2, 1, 1, 1);
        // full vector load
        step(16'hFFFF, 0, 2, 1, 0, 0);
        step(16'h0000, 0, 2, 0, 1, 16);

        for (int i = 0; i < 3000; i++) begin
            int op;
            op = $urandom_range(0, 9);
            step(N'($urandom), $urandom_range(0, N-1), $urandom_range(0, 3),
                 op < 2, op >= 1 && op < 6, $urandom_range(0, 3));
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule